// File: doc/BRIEF.md
# Sliding-Window Byte SAD Unit

This block matches a short row of pixels against a longer row in one operation. It takes two 128-bit operands, each holding sixteen unsigned bytes, and a 3-bit selector. The selector chooses a 4-byte group from the first operand, called the source. It also chooses an 11-byte window from the second operand, called the destination. The block then returns eight sums of absolute differences. Sum k compares the source group against the four destination bytes that start k bytes into the window. The eight sums therefore cover eight candidate alignments of the source group along the destination row.

The unit is pipelined with two register stages. It accepts a new operation on every clock cycle. A valid flag travels alongside each operation and marks the output word that holds the packed result. Motion-estimation datapaths can issue operations back to back, one per cycle, and collect the results two cycles later.

Top module: `sad_multi_offset`

## Requirements
- R1: For k = 0..7, sum k equals the sum over j = 0..3 of |src byte (G+j) − dst byte (B+k+j)|. G is the source group offset and B is the destination window base.
- R2: Selector bit 2 sets the destination window base B. A value of 0 gives B = 0, so the window uses dst bytes 0..10. A value of 1 gives B = 4, so the window uses dst bytes 4..14.
- R3: Selector bits 1:0 set the source group offset G = 4 × sel[1:0]. The values 0, 1, 2 and 3 select src bytes 0..3, 4..7, 8..11 and 12..15.
- R4: All bytes are unsigned. Each absolute difference is the larger byte minus the smaller byte, so 0xFF against 0x00 gives 255 in either order.
- R5: Sum k is zero-extended into bits 16k+15:16k of sad_out. Sum 0 sits in bits 15:0 and sum 7 in bits 127:112. No lane exceeds 1020.
- R6: Byte i of each operand occupies bits 8i+7:8i.
- R7: valid_out is high in exactly those cycles that come two clock edges after a cycle in which valid_in was high. Operations may be issued on every cycle.
- R8: A synchronous active-high reset drives valid_out low. After reset, valid_out stays low until an operation accepted after reset reaches the output.
- R9: When every byte of both operands holds the same value, all eight sums are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Operation present on the inputs this cycle |
| src_in | input | 128 | Source operand, sixteen unsigned bytes |
| dst_in | input | 128 | Destination operand, sixteen unsigned bytes |
| sel_in | input | 3 | Bit 2 selects the destination window; bits 1:0 select the source group |
| valid_out | output | 1 | Result valid on sad_out |
| sad_out | output | 128 | Eight 16-bit sums, sum 0 in the low lane |

## Verification
All-0xFF against all-0x00 is applied in both directions. This pattern shows whether the absolute difference is formed unsigned or signed, and it drives every lane to the 1020 limit. A source whose bytes hold their own indices is paired with a zero destination, and this identifies which source group each sel[1:0] value picks. A destination whose bytes hold their own indices is paired with a zero source, and this gives lane values of 4k+6 or 4k+22, which expose the window base and the slide direction. Random operands under all eight selector values, mixed with idle cycles and a reset in mid-stream, are checked against a loop model. These cover lane packing, back-to-back issue and valid timing.

// File: rtl/sad_pkg.sv
package sad_pkg;
  localparam int BYTE_W_D   = 8;
  localparam int GROUP_D    = 4;
  localparam int LANES_D    = 8;
  localparam int SUM_W_D    = 16;
  localparam int SEL_W      = 3;
  localparam int N_GROUPS   = 4;
endpackage

// File: rtl/sad_operand_mux.sv
module sad_operand_mux #(
  parameter int BYTE_W = 8,
  parameter int GROUP  = 4,
  parameter int LANES  = 8,
  localparam int OPER_BYTES = GROUP * sad_pkg::N_GROUPS,
  localparam int OPER_W     = OPER_BYTES * BYTE_W,
  localparam int WIN_BYTES  = LANES + GROUP - 1,
  localparam int GRP_W      = GROUP * BYTE_W,
  localparam int WIN_W      = WIN_BYTES * BYTE_W
) (
  input  logic [OPER_W-1:0]          src,
  input  logic [OPER_W-1:0]          dst,
  input  logic [sad_pkg::SEL_W-1:0]  sel,
  output logic [GRP_W-1:0]           src_grp,
  output logic [WIN_W-1:0]           dst_win
);
  int src_off;
  int dst_off;

  always_comb begin
    src_off = int'(sel[1:0]) * GRP_W;
    dst_off = int'(sel[2]) * GRP_W;
    src_grp = src[src_off +: GRP_W];
    dst_win = dst[dst_off +: WIN_W];
  end
endmodule

// File: rtl/sad_diff_stage.sv
module sad_diff_stage #(
  parameter int BYTE_W = 8,
  parameter int GROUP  = 4,
  parameter int LANES  = 8,
  localparam int WIN_BYTES = LANES + GROUP - 1,
  localparam int GRP_W     = GROUP * BYTE_W,
  localparam int WIN_W     = WIN_BYTES * BYTE_W,
  localparam int DIFF_W    = LANES * GROUP * BYTE_W
) (
  input  logic              clk,
  input  logic [GRP_W-1:0]  src_grp,
  input  logic [WIN_W-1:0]  dst_win,
  output logic [DIFF_W-1:0] diff_q
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    for (genvar j = 0; j < GROUP; j++) begin : g_term
      logic [BYTE_W-1:0] a_b, d_b, mag;
      assign a_b = src_grp[j*BYTE_W +: BYTE_W];
      assign d_b = dst_win[(k+j)*BYTE_W +: BYTE_W];
      assign mag = (a_b > d_b) ? (a_b - d_b) : (d_b - a_b);
      always_ff @(posedge clk) begin
        diff_q[(k*GROUP+j)*BYTE_W +: BYTE_W] <= mag;
      end
    end
  end
endmodule

// File: rtl/sad_sum_stage.sv
module sad_sum_stage #(
  parameter int BYTE_W = 8,
  parameter int GROUP  = 4,
  parameter int LANES  = 8,
  parameter int SUM_W  = 16,
  localparam int DIFF_W = LANES * GROUP * BYTE_W,
  localparam int OUT_W  = LANES * SUM_W
) (
  input  logic              clk,
  input  logic [DIFF_W-1:0] diff_q,
  output logic [OUT_W-1:0]  sum_q
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [SUM_W-1:0] acc;
    always_comb begin
      acc = '0;
      for (int j = 0; j < GROUP; j++) begin
        acc = acc + {{(SUM_W-BYTE_W){1'b0}}, diff_q[(k*GROUP+j)*BYTE_W +: BYTE_W]};
      end
    end
    always_ff @(posedge clk) begin
      sum_q[k*SUM_W +: SUM_W] <= acc;
    end
  end
endmodule

// File: rtl/sad_multi_offset.sv
module sad_multi_offset #(
  parameter int BYTE_W = sad_pkg::BYTE_W_D,
  parameter int GROUP  = sad_pkg::GROUP_D,
  parameter int LANES  = sad_pkg::LANES_D,
  parameter int SUM_W  = sad_pkg::SUM_W_D,
  localparam int OPER_W = GROUP * sad_pkg::N_GROUPS * BYTE_W,
  localparam int OUT_W  = LANES * SUM_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      valid_in,
  input  logic [OPER_W-1:0]         src_in,
  input  logic [OPER_W-1:0]         dst_in,
  input  logic [sad_pkg::SEL_W-1:0] sel_in,
  output logic                      valid_out,
  output logic [OUT_W-1:0]          sad_out
);
  localparam int GRP_W  = GROUP * BYTE_W;
  localparam int WIN_W  = (LANES + GROUP - 1) * BYTE_W;
  localparam int DIFF_W = LANES * GROUP * BYTE_W;

  logic [GRP_W-1:0]  src_grp;
  logic [WIN_W-1:0]  dst_win;
  logic [DIFF_W-1:0] diff_q;
  logic              valid_s1;

  sad_operand_mux #(.BYTE_W(BYTE_W), .GROUP(GROUP), .LANES(LANES)) u_mux (
    .src(src_in), .dst(dst_in), .sel(sel_in),
    .src_grp(src_grp), .dst_win(dst_win)
  );

  sad_diff_stage #(.BYTE_W(BYTE_W), .GROUP(GROUP), .LANES(LANES)) u_diff (
    .clk(clk), .src_grp(src_grp), .dst_win(dst_win), .diff_q(diff_q)
  );

  sad_sum_stage #(.BYTE_W(BYTE_W), .GROUP(GROUP), .LANES(LANES), .SUM_W(SUM_W)) u_sum (
    .clk(clk), .diff_q(diff_q), .sum_q(sad_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_s1  <= 1'b0;
      valid_out <= 1'b0;
    end else begin
      valid_s1  <= valid_in;
      valid_out <= valid_s1;
    end
  end
endmodule

// File: rtl/sad_multi_offset_chk.sv
module sad_multi_offset_chk #(
  parameter int BYTE_W = sad_pkg::BYTE_W_D,
  parameter int GROUP  = sad_pkg::GROUP_D,
  parameter int LANES  = sad_pkg::LANES_D,
  parameter int SUM_W  = sad_pkg::SUM_W_D,
  localparam int OPER_W = GROUP * sad_pkg::N_GROUPS * BYTE_W,
  localparam int OUT_W  = LANES * SUM_W,
  localparam int MAX_SUM = GROUP * ((1 << BYTE_W) - 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              valid_in,
  input logic [OPER_W-1:0] src_in,
  input logic [OPER_W-1:0] dst_in,
  input logic              valid_out,
  input logic [OUT_W-1:0]  sad_out
);
  logic lanes_in_range;
  logic uniform_eq;

  always_comb begin
    lanes_in_range = 1'b1;
    for (int k = 0; k < LANES; k++) begin
      if (int'(sad_out[k*SUM_W +: SUM_W]) > MAX_SUM) lanes_in_range = 1'b0;
    end
    uniform_eq = 1'b1;
    for (int i = 0; i < OPER_W/BYTE_W; i++) begin
      if (src_in[i*BYTE_W +: BYTE_W] != src_in[BYTE_W-1:0]) uniform_eq = 1'b0;
      if (dst_in[i*BYTE_W +: BYTE_W] != src_in[BYTE_W-1:0]) uniform_eq = 1'b0;
    end
  end

  p_latency_r7: assert property (@(posedge clk) disable iff (rst)
    valid_in |-> ##2 valid_out);

  p_no_spurious_r7: assert property (@(posedge clk) disable iff (rst)
    !valid_in |-> ##2 !valid_out);

  p_reset_clears_r8: assert property (@(posedge clk)
    rst |=> !valid_out);

  p_lane_bound_r5: assert property (@(posedge clk) disable iff (rst)
    valid_out |-> lanes_in_range);

  p_equal_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (valid_in && uniform_eq) |-> ##2 (sad_out == '0));
endmodule

bind sad_multi_offset sad_multi_offset_chk #(
  .BYTE_W(BYTE_W), .GROUP(GROUP), .LANES(LANES), .SUM_W(SUM_W)
) u_chk (
  .clk(clk), .rst(rst), .valid_in(valid_in), .src_in(src_in), .dst_in(dst_in),
  .valid_out(valid_out), .sad_out(sad_out)
);

// File: tb/sad_multi_offset_bench.sv
module sad_multi_offset_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         valid_in = 1'b0;
  logic [127:0] src_in = '0;
  logic [127:0] dst_in = '0;
  logic [2:0]   sel_in = '0;
  logic         valid_out;
  logic [127:0] sad_out;

  int checks = 0;
  int fails  = 0;
  bit           ev [2] = '{1'b0, 1'b0};
  logic [127:0] ex [2] = '{128'b0, 128'b0};
  string        et [2] = '{"R8", "R8"};

  always #2 clk = ~clk;

  sad_multi_offset u_sad_multi_offset (
    .clk(clk), .rst(rst), .valid_in(valid_in), .src_in(src_in), .dst_in(dst_in),
    .sel_in(sel_in), .valid_out(valid_out), .sad_out(sad_out)
  );

  function automatic logic [127:0] model(input logic [127:0] s, input logic [127:0] d,
                                         input logic [2:0] sl);
    logic [127:0] r = '0;
    for (int k = 0; k < 8; k++) begin
      int acc = 0;
      for (int j = 0; j < 4; j++) begin
        int a = int'(s[8*(4*int'(sl[1:0]) + j) +: 8]);
        int b = int'(d[8*(4*int'(sl[2]) + k + j) +: 8]);
        acc += (a > b) ? a - b : b - a;
      end
      r[16*k +: 16] = 16'(acc);
    end
    return r;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  function automatic logic [127:0] index_bytes();
    logic [127:0] r;
    for (int i = 0; i < 16; i++) r[8*i +: 8] = 8'(i);
    return r;
  endfunction

  function automatic logic [127:0] lanes_of(input int v);
    logic [127:0] r;
    for (int k = 0; k < 8; k++) r[16*k +: 16] = 16'(v);
    return r;
  endfunction

  task automatic expect_direct(input logic [127:0] got, input logic [127:0] want, input string tag);
    checks++;
    if (got !== want) begin
      fails++;
      $display("FAIL %s model cross-check actual=%h expected=%h", tag, got, want);
    end
  endtask

  task automatic step(input bit rs, input bit v, input logic [127:0] s, input logic [127:0] d,
                      input logic [2:0] sl, input string tag);
    @(negedge clk);
    checks++;
    if (valid_out !== ev[1]) begin
      fails++;
      $display("FAIL R7/R8 (%s) valid_out actual=%b expected=%b", et[1], valid_out, ev[1]);
    end else if (ev[1]) begin
      checks++;
      if (sad_out !== ex[1]) begin
        fails++;
        $display("FAIL %s sad_out actual=%h expected=%h", et[1], sad_out, ex[1]);
      end
    end
    ev[1] = ev[0]; ex[1] = ex[0]; et[1] = et[0];
    ev[0] = v && !rs; ex[0] = model(s, d, sl); et[0] = tag;
    if (rs) ev[1] = 1'b0;
    rst = rs; valid_in = v; src_in = s; dst_in = d; sel_in = sl;
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    // R8: reset state, valid_out low while reset is held
    for (int i = 0; i < 3; i++) step(1, 1, '0, '0, 3'd0, "R8");

    // Direct checks of the bench's own expectations against the requirements
    expect_direct(model({16{8'hFF}}, '0, 3'd5), lanes_of(1020), "R4");
    expect_direct(model(index_bytes(), '0, 3'd3), lanes_of(54), "R3");

    // R4/R5: all-0xFF vs all-0x00 in both directions, every selector; lanes = 1020
    for (int s = 0; s < 8; s++) step(0, 1, {16{8'hFF}}, '0, 3'(s), "R4");
    for (int s = 0; s < 8; s++) step(0, 1, '0, {16{8'hFF}}, 3'(s), "R5");

    // R3/R6: source bytes carry their index, dst zero -> group sum per sel[1:0]
    for (int s = 0; s < 8; s++) step(0, 1, index_bytes(), '0, 3'(s), "R3");

    // R2/R1: dst bytes carry their index, src zero -> lane k = 4k+6 or 4k+22
    step(0, 1, '0, index_bytes(), 3'b000, "R2");
    step(0, 1, '0, index_bytes(), 3'b100, "R2");
    step(0, 1, '0, index_bytes(), 3'b011, "R1");

    // R9: uniform equal operands give zero
    step(0, 1, {16{8'h5A}}, {16{8'h5A}}, 3'b110, "R9");
    step(0, 1, {16{8'hFF}}, {16{8'hFF}}, 3'b001, "R9");

    // R7: idle cycles between operations
    step(0, 0, rnd128(), rnd128(), 3'd2, "R7");
    step(0, 1, rnd128(), rnd128(), 3'd6, "R7");
    step(0, 0, rnd128(), rnd128(), 3'd1, "R7");

    // R8: reset in mid-stream with valid_in held high
    step(0, 1, rnd128(), rnd128(), 3'd4, "R8");
    step(1, 1, rnd128(), rnd128(), 3'd7, "R8");
    step(0, 1, rnd128(), rnd128(), 3'd3, "R8");

    // R1/R5/R6: random operands across all selectors, occasional bubbles
    for (int n = 0; n < 400; n++) begin
      bit v = ($urandom % 5) != 0;
      step(0, v, rnd128(), rnd128(), 3'(n % 8), "R1");
    end

    step(0, 0, '0, '0, 3'd0, "R7");
    step(0, 0, '0, '0, 3'd0, "R7");
    step(0, 0, '0, '0, 3'd0, "R7");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule